// File: doc/BRIEF.md
# Per-Set Way Partition Allocator

This block holds the way allocation of every core for one set of a shared cache and rebalances it on request. Each core supplies two event pulses. One fires when the core hits the least-recently-used line of its own share. The other fires on a far miss, meaning a miss that more ways would have turned into a hit; that detection happens upstream. The block counts both kinds of event per core in saturating counters.

When a repartition is requested, the block freezes the counts and prices each core. Giving up a way costs the core its LRU-hit count. Taking a way gains its far-miss count scaled by the share of ways it does not yet own. The block then pairs the best receiver with the cheapest donor and moves one way whenever that raises the estimated hit total. It repeats this for the remaining cores. Finally it clears its counters and pulses done with the new per-core limits, which the replacement logic then enforces.

Top module: `set_part_alloc`

## Requirements
- R1: After reset every core owns ASSOC/NUM_CORES ways (core 0 also takes the remainder), and busy_o and done_o are low.
- R2: Each core has an LRU-hit counter and a far-miss counter, each CNT_W (8) bits wide. Each counter adds one per input pulse while counting is enabled, and holds at 255 instead of wrapping.
- R3: Event pulses have no effect while busy_o is high or in the cycle a request is accepted.
- R4: A core's loss is its LRU-hit count. Its gain is (far-miss count × (ASSOC − ways)) >> log2(ASSOC), computed from the allocation held at the request.
- R5: Each step picks the receiver with the largest gain among unpaired cores, with the lowest index winning ties. The donor is the unpaired core other than the receiver that has more than one way and the smallest loss, again with the lowest index winning ties. One way moves only if gain is strictly greater than loss; the first step that fails ends the repartition.
- R6: In one repartition each core's allocation changes by at most one way.
- R7: Allocations always sum to ASSOC and no core ever holds fewer than one way.
- R8: done_o is a one-cycle pulse seen S+2 cycles after the request, where S is the number of ways moved (at most NUM_CORES/2). way_limit_o is final when it rises, and all counters read zero afterwards.
- R9: A request raised while busy_o is high is ignored and starts no further repartition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lru_hit_i | input | NUM_CORES | Per-core pulse: hit in the LRU line of the core's share |
| far_miss_i | input | NUM_CORES | Per-core pulse: miss that extra ways would have caught |
| repart_req_i | input | 1 | Start a repartition |
| busy_o | output | 1 | Repartition in progress |
| done_o | output | 1 | One-cycle pulse when new limits are valid |
| way_limit_o | output | NUM_CORES*WAY_W | Way limit of core i at bits [i*WAY_W +: WAY_W] |

## Verification
The request is taken at the first clock edge after it is raised, and busy_o is high one cycle later. Each successful move takes one further edge, and a final edge clears the counters and raises done_o. That puts done_o S+2 cycles after the request. The bench samples on falling edges and counts those cycles against a move count from its own arithmetic model of the pairing. It compares every limit on the cycle done_o is seen. Event pulses driven during busy cycles must leave the model's next result unchanged, which shows that they were ignored.

// File: rtl/part_pkg.sv
package part_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } part_st_e;
endpackage

// File: rtl/part_evt_cnt.sv
module part_evt_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (en_i && evt_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && !clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R3
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/part_gain_calc.sv
module part_gain_calc #(
  parameter int CNT_W  = 8,
  parameter int ASSOC  = 32,
  parameter int WAY_W  = 6,
  parameter int GAIN_W = 14
) (
  input  logic [CNT_W-1:0]  far_i,
  input  logic [WAY_W-1:0]  ways_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int SHIFT = $clog2(ASSOC);

  logic [WAY_W-1:0]  free_w;
  logic [GAIN_W-1:0] prod;

  // gain = far * (assoc - ways) / assoc, assoc a power of two
  always_comb begin
    free_w = WAY_W'(ASSOC) - ways_i;
    prod   = GAIN_W'(far_i) * GAIN_W'(free_w);
    gain_o = prod >> SHIFT;
  end
endmodule

// File: rtl/part_pair_pick.sv
module part_pair_pick #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  parameter int WAY_W     = 6,
  parameter int GAIN_W    = 14,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_CORES-1:0][GAIN_W-1:0] gain_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0]  loss_i,
  input  logic [NUM_CORES-1:0][WAY_W-1:0]  ways_i,
  input  logic [NUM_CORES-1:0]             used_i,
  output logic [IDX_W-1:0]                 rx_o,
  output logic [IDX_W-1:0]                 dn_o,
  output logic                             ok_o
);
  logic              rx_found, dn_found;
  logic [GAIN_W-1:0] best_g;
  logic [CNT_W-1:0]  best_l;

  always_comb begin
    rx_found = 1'b0;
    rx_o     = '0;
    best_g   = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (!used_i[i] && (!rx_found || gain_i[i] > best_g)) begin
        rx_found = 1'b1;
        rx_o     = IDX_W'(i);
        best_g   = gain_i[i];
      end
    end
    dn_found = 1'b0;
    dn_o     = '0;
    best_l   = '0;
    for (int j = 0; j < NUM_CORES; j++) begin
      if (!used_i[j] && IDX_W'(j) != rx_o && ways_i[j] > WAY_W'(1) &&
          (!dn_found || loss_i[j] < best_l)) begin
        dn_found = 1'b1;
        dn_o     = IDX_W'(j);
        best_l   = loss_i[j];
      end
    end
    ok_o = rx_found && dn_found && (best_g > GAIN_W'(best_l));
  end
endmodule

// File: rtl/set_part_alloc.sv
module set_part_alloc #(
  parameter int NUM_CORES = 4,
  parameter int ASSOC     = 32,
  parameter int CNT_W     = 8,
  localparam int WAY_W    = $clog2(ASSOC + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CORES-1:0]       lru_hit_i,
  input  logic [NUM_CORES-1:0]       far_miss_i,
  input  logic                       repart_req_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [NUM_CORES*WAY_W-1:0] way_limit_o
);
  import part_pkg::*;

  localparam int GAIN_W  = CNT_W + WAY_W;
  localparam int IDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int BASE    = ASSOC / NUM_CORES;
  localparam int REM     = ASSOC % NUM_CORES;
  localparam int SCAN_W  = $clog2(NUM_CORES) + 2;
  localparam int MAX_MOV = NUM_CORES / 2;

  part_st_e                          state_q;
  logic [NUM_CORES-1:0][WAY_W-1:0]   ways_q, snap_ways_q;
  logic [NUM_CORES-1:0][GAIN_W-1:0]  gain_now, snap_gain_q;
  logic [NUM_CORES-1:0][CNT_W-1:0]   lru_cnt, far_cnt, snap_loss_q;
  logic [NUM_CORES-1:0]              used_q;
  logic                              done_q;
  logic [IDX_W-1:0]                  rx_idx, dn_idx;
  logic                              step_ok;
  logic                              cnt_en, cnt_clr;

  assign cnt_en  = (state_q == ST_IDLE) && !repart_req_i;
  assign cnt_clr = (state_q == ST_SCAN) && !step_ok;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    part_evt_cnt #(.CNT_W(CNT_W)) u_lru_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en), .clr_i(cnt_clr),
      .evt_i(lru_hit_i[g]), .cnt_o(lru_cnt[g])
    );
    part_evt_cnt #(.CNT_W(CNT_W)) u_far_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en), .clr_i(cnt_clr),
      .evt_i(far_miss_i[g]), .cnt_o(far_cnt[g])
    );
    part_gain_calc #(.CNT_W(CNT_W), .ASSOC(ASSOC), .WAY_W(WAY_W), .GAIN_W(GAIN_W)) u_gain (
      .far_i(far_cnt[g]), .ways_i(ways_q[g]), .gain_o(gain_now[g])
    );
    assign way_limit_o[g*WAY_W +: WAY_W] = ways_q[g];
  end

  part_pair_pick #(
    .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .WAY_W(WAY_W), .GAIN_W(GAIN_W), .IDX_W(IDX_W)
  ) u_pick (
    .gain_i(snap_gain_q), .loss_i(snap_loss_q), .ways_i(ways_q), .used_i(used_q),
    .rx_o(rx_idx), .dn_o(dn_idx), .ok_o(step_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      used_q      <= '0;
      done_q      <= 1'b0;
      snap_gain_q <= '0;
      snap_loss_q <= '0;
      for (int i = 0; i < NUM_CORES; i++) begin
        ways_q[i]      <= (i == 0) ? WAY_W'(BASE + REM) : WAY_W'(BASE);
        snap_ways_q[i] <= (i == 0) ? WAY_W'(BASE + REM) : WAY_W'(BASE);
      end
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (repart_req_i) begin
          state_q     <= ST_SCAN;
          used_q      <= '0;
          snap_gain_q <= gain_now;
          snap_loss_q <= lru_cnt;
          snap_ways_q <= ways_q;
        end
        default: if (step_ok) begin
          ways_q[rx_idx] <= ways_q[rx_idx] + 1'b1;
          ways_q[dn_idx] <= ways_q[dn_idx] - 1'b1;
          used_q[rx_idx] <= 1'b1;
          used_q[dn_idx] <= 1'b1;
        end else begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      endcase
    end
  end

  assign busy_o = (state_q == ST_SCAN);
  assign done_o = done_q;

  // assertion support
  logic [SCAN_W-1:0] scan_cnt_q;
  int unsigned       ways_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 scan_cnt_q <= '0;
    else if (state_q == ST_SCAN) scan_cnt_q <= scan_cnt_q + 1'b1;
    else                         scan_cnt_q <= '0;
  end

  always_comb begin
    ways_sum = 0;
    for (int i = 0; i < NUM_CORES; i++) ways_sum += int'(ways_q[i]);
  end

  // R7
  sum_assoc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ways_sum == ASSOC);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  scan_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(scan_cnt_q) <= MAX_MOV + 1);
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && repart_req_i) |=> $stable(snap_loss_q));

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_way_chk
    // R7
    min_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ways_q[k] != '0);
    // R6
    step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((WAY_W+1)'(ways_q[k]) <= (WAY_W+1)'(snap_ways_q[k]) + (WAY_W+1)'(1)) &&
      ((WAY_W+1)'(ways_q[k]) + (WAY_W+1)'(1) >= (WAY_W+1)'(snap_ways_q[k])));
  end
endmodule

// File: tb/set_part_alloc_tb.sv
`timescale 1ns/1ps
module set_part_alloc_tb;
  localparam int N    = 4;
  localparam int A    = 8;
  localparam int CW   = 8;
  localparam int WW   = $clog2(A + 1);
  localparam int SH   = $clog2(A);
  localparam int MAXC = (1 << CW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  lru_hit_i = '0;
  logic [N-1:0]  far_miss_i = '0;
  logic          repart_req_i = 1'b0;
  logic          busy_o, done_o;
  logic [N*WW-1:0] way_limit_o;

  set_part_alloc #(.NUM_CORES(N), .ASSOC(A), .CNT_W(CW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lru_hit_i(lru_hit_i), .far_miss_i(far_miss_i),
    .repart_req_i(repart_req_i), .busy_o(busy_o), .done_o(done_o), .way_limit_o(way_limit_o)
  );

  always #2 clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  int m_ways[N];
  int m_lru[N];
  int m_far[N];
  int cyc_cnt = 0;

  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<190000 cycles", cyc_cnt);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int i);
    return int'(way_limit_o[i*WW +: WW]);
  endfunction

  // bench model of one repartition (R4, R5)
  task automatic model_round(output int exp_w[N], output int moves);
    int gain[N];
    bit used[N];
    moves = 0;
    for (int i = 0; i < N; i++) begin
      exp_w[i] = m_ways[i];
      gain[i]  = (m_far[i] * (A - m_ways[i])) >> SH;
      used[i]  = 1'b0;
    end
    for (int s = 0; s < N; s++) begin
      int rx = -1, dn = -1;
      for (int i = 0; i < N; i++)
        if (!used[i] && (rx < 0 || gain[i] > gain[rx])) rx = i;
      for (int j = 0; j < N; j++)
        if (!used[j] && j != rx && exp_w[j] > 1 && (dn < 0 || m_lru[j] < m_lru[dn])) dn = j;
      if (rx < 0 || dn < 0 || gain[rx] <= m_lru[dn]) break;
      exp_w[rx]++;
      exp_w[dn]--;
      used[rx] = 1'b1;
      used[dn] = 1'b1;
      moves++;
    end
  endtask

  // counted event pulses, idle phase (R2)
  task automatic drive_events(input int cycles, input logic [N-1:0] lmask,
                              input logic [N-1:0] fmask, input int pct);
    for (int c = 0; c < cycles; c++) begin
      logic [N-1:0] lv, fv;
      @(negedge clk_i);
      for (int i = 0; i < N; i++) begin
        lv[i] = lmask[i] && (($urandom % 100) < pct);
        fv[i] = fmask[i] && (($urandom % 100) < pct);
        if (lv[i] && m_lru[i] < MAXC) m_lru[i]++;
        if (fv[i] && m_far[i] < MAXC) m_far[i]++;
      end
      lru_hit_i  = lv;
      far_miss_i = fv;
    end
    @(negedge clk_i);
    lru_hit_i  = '0;
    far_miss_i = '0;
  endtask

  task automatic do_round(input string tag, input bit rereq);
    int exp_w[N];
    int moves, wait_c;
    model_round(exp_w, moves);
    @(negedge clk_i);
    repart_req_i = 1'b1;
    // R3: pulses in the accept cycle are ignored
    lru_hit_i  = '1;
    far_miss_i = '1;
    @(negedge clk_i);
    repart_req_i = rereq;  // R9: request held into busy
    wait_c = 1;
    check(busy_o == 1'b1, "R8 busy after request", busy_o, 1);
    while (!done_o && wait_c < 20) begin
      // R3: pulses while busy are ignored
      lru_hit_i  = N'($urandom);
      far_miss_i = N'($urandom);
      @(negedge clk_i);
      repart_req_i = 1'b0;
      wait_c++;
    end
    lru_hit_i  = '0;
    far_miss_i = '0;
    check(done_o == 1'b1 && wait_c == moves + 2, {"R8 done latency ", tag}, wait_c, moves + 2);
    for (int i = 0; i < N; i++)
      check(lim(i) == exp_w[i], {"R5 R4 R6 limit ", tag}, lim(i), exp_w[i]);
    begin
      int s = 0;
      for (int i = 0; i < N; i++) s += lim(i);
      check(s == A, "R7 sum of limits", s, A);
    end
    @(negedge clk_i);
    check(done_o == 1'b0, "R8 done is one cycle", done_o, 0);
    if (rereq) begin
      repeat (3) begin
        check(busy_o == 1'b0 && done_o == 1'b0, "R9 no restart", busy_o, 0);
        @(negedge clk_i);
      end
    end
    for (int i = 0; i < N; i++) begin
      m_ways[i] = exp_w[i];
      m_lru[i]  = 0;
      m_far[i]  = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_ways[i] = A / N + ((i == 0) ? A % N : 0);
      m_lru[i]  = 0;
      m_far[i]  = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1
    for (int i = 0; i < N; i++)
      check(lim(i) == m_ways[i], "R1 reset limit", lim(i), m_ways[i]);
    check(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    check(done_o == 1'b0, "R1 done at reset", done_o, 0);
    rst_ni = 1'b1;

    // R5: all counts zero, no move (gain equals loss)
    do_round("R5 zero", 1'b0);

    // R2: far misses saturate; gain 255*6>>3=191 beats loss 190
    drive_events(300, 4'b0000, 4'b0001, 100);
    drive_events(190, 4'b1110, 4'b0000, 100);
    do_round("R2 saturate", 1'b0);

    // R5: strict compare, gain equals loss gives no move
    drive_events(300, 4'b0000, 4'b0010, 100);
    for (int c = 0; c < 1; c++) ;
    drive_events((255 * (A - m_ways[1])) >> SH, 4'b1101, 4'b0000, 100);
    do_round("R5 strict", 1'b0);

    // R9: second request during busy is ignored
    drive_events(40, 4'b1111, 4'b1111, 50);
    do_round("R9 rereq", 1'b1);

    // R4 R5 R6 R7: sweep of random event mixes
    for (int r = 0; r < 150; r++) begin
      drive_events(20 + ($urandom % 400), N'($urandom), N'($urandom), 10 + ($urandom % 90));
      do_round("sweep", (r % 7) == 3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule